// File: doc/BRIEF.md
# Byte-Wide Keyboard and Printer Bus Port

This block is a memory-mapped slave on a simple interlocked processor bus. It gives software one 8-bit input channel, fed by a keyboard-style source that delivers an already encoded and debounced code with a strobe. It also gives one 8-bit output channel to a printer-style sink that reports when it is free. The processor reaches three byte registers through a single word-aligned window: the last received code, the outgoing byte, and a status byte. Each transfer is a full request/acknowledge exchange. The master raises its request, the port answers with an acknowledge, and the acknowledge falls only after the request falls.

On the device side, a rising edge on the input strobe latches the code and marks it as waiting. When the output device signals that it is free and no byte is pending, the port reports that it can take a new byte. A bus write of the outgoing byte drives it onto the device lines with a strobe, and the strobe stays up until the device shows it is busy. The off-chip three-state data drivers are modelled as a read data bus plus a separate drive-enable output.

Top module: `kbd_prn_port`

## Requirements
- R1: The port acknowledges only when address bits 31..2 equal bits 31..2 of parameter BASE_ADDR. For any other address, `bus_srdy` stays 0.
- R2: Address bits 1..0 select the register. 0 is the input byte (read only), 1 is the output byte (write only) and 2 is status (read only). Select 3, a write to 0 or 2, or a read of 1 is never acknowledged and changes no state.
- R3: If `bus_mrdy` is high with a legal access while `bus_srdy` is low, `bus_srdy` rises on the next clock. It then stays high while `bus_mrdy` stays high, and falls on the clock after `bus_mrdy` is seen low.
- R4: `bus_rd_en` is high only together with `bus_srdy` during an acknowledged read, and only if `bus_mrdy` was high on the previous clock. While it is high, `bus_rdata` holds the selected register's value as it was when the access was accepted.
- R5: A 0-to-1 change of `key_valid` copies `key_code` into the input byte and sets status bit 0 (byte waiting). Both are visible from the next clock.
- R6: An accepted read of the input byte returns the stored byte and clears status bit 0. If a new strobe edge arrives in the same cycle, bit 0 stays set.
- R7: A strobe edge that arrives while status bit 0 is set overwrites the input byte and sets status bit 2 (overrun). An accepted status read returns the byte and then clears bit 2.
- R8: Status bit 1 (output free) is set when `prn_idle` is high while `prn_valid` is low. An accepted write of the output byte clears it.
- R9: An accepted write of the output byte puts the written value on `prn_data` and sets `prn_valid` on the next clock. `prn_valid` falls on the clock after `prn_idle` is seen low.
- R10: Status bits 7..3 read as 0.
- R11: After reset, `bus_srdy`, `bus_rd_en`, `bus_rdata`, `prn_valid`, `prn_data` and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address from the processor |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_mrdy | input | 1 | Master request (Master-ready) |
| bus_wdata | input | 8 | Write data from the processor |
| bus_srdy | output | 1 | Slave acknowledge (Slave-ready) |
| bus_rdata | output | 8 | Read data toward the bus drivers |
| bus_rd_en | output | 1 | Enable for the three-state read drivers |
| key_code | input | 8 | Encoded code from the input device |
| key_valid | input | 1 | Input strobe; its rising edge latches the code |
| prn_idle | input | 1 | Output device is free to take a byte |
| prn_data | output | 8 | Byte presented to the output device |
| prn_valid | output | 1 | Byte on `prn_data` is new |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that the master keeps address, direction and write data stable while its request is high and the acknowledge has not yet fallen, and that it issues no new request before the acknowledge drops. The bench changes every input only on the falling clock edge. Its bus tasks hold the address and direction from request to release, and wait for the acknowledge to fall before they return. Random keystrokes drop the strobe for at least one cycle between edges, so that each keystroke produces exactly one rising edge.

// File: rtl/kbd_prn_pkg.sv
package kbd_prn_pkg;
  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_PRN  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } kp_sel_e;

  localparam int SEL_W     = 2;
  localparam int ST_FULL   = 0;
  localparam int ST_FREE   = 1;
  localparam int ST_OVR    = 2;
endpackage

// File: rtl/kp_bus_slave.sv
module kp_bus_slave
  import kbd_prn_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rnw,
  input  logic              mrdy,
  input  logic [DATA_W-1:0] key_byte,
  input  logic [DATA_W-1:0] stat_byte,
  output logic              srdy,
  output logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_key,
  output logic              rd_stat,
  output logic              wr_prn
);
  logic    hit;
  logic    legal;
  logic    accept;
  kp_sel_e sel;

  assign hit    = (addr[ADDR_W-1:SEL_W] == BASE_ADDR[ADDR_W-1:SEL_W]);
  assign sel    = kp_sel_e'(addr[SEL_W-1:0]);
  assign legal  = hit && ((rnw && (sel == SEL_KEY || sel == SEL_STAT)) ||
                          (!rnw && sel == SEL_PRN));
  assign accept = !srdy && mrdy && legal;

  assign rd_key  = accept && rnw && (sel == SEL_KEY);
  assign rd_stat = accept && rnw && (sel == SEL_STAT);
  assign wr_prn  = accept && !rnw;

  always_ff @(posedge clk) begin
    if (rst) begin
      srdy  <= 1'b0;
      rd_en <= 1'b0;
      rdata <= '0;
    end else if (accept) begin
      srdy  <= 1'b1;
      rd_en <= rnw;
      rdata <= !rnw ? '0 : (sel == SEL_KEY) ? key_byte : stat_byte;
    end else if (srdy && !mrdy) begin
      srdy  <= 1'b0;
      rd_en <= 1'b0;
      rdata <= '0;
    end
  end

  // R3
  srdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    srdy && mrdy |=> srdy);
  // R3
  srdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    srdy && !mrdy |=> !srdy);
  // R1
  no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !srdy && mrdy && !hit |=> !srdy);
  // R4
  rd_en_srdy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> srdy);
  // R4
  rd_en_mrdy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> $past(mrdy));
endmodule

// File: rtl/kp_key_chan.sv
module kp_key_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] code,
  input  logic              strobe,
  input  logic              rd_clr,
  input  logic              stat_clr,
  output logic [DATA_W-1:0] held,
  output logic              full,
  output logic              ovr
);
  logic strobe_d;
  logic edge_seen;

  assign edge_seen = strobe && !strobe_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_d <= 1'b0;
      held     <= '0;
      full     <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      strobe_d <= strobe;
      if (edge_seen) held <= code;
      if (edge_seen)   full <= 1'b1;
      else if (rd_clr) full <= 1'b0;
      if (edge_seen && full && !rd_clr) ovr <= 1'b1;
      else if (stat_clr)                ovr <= 1'b0;
    end
  end

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> full && held == $past(code));
  // R7
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    edge_seen && full && !rd_clr |=> ovr);
  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_clr && !edge_seen |=> !full);
endmodule

// File: rtl/kp_prn_chan.sv
module kp_prn_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              idle,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_valid,
  output logic              free
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_byte  <= '0;
      out_valid <= 1'b0;
      free      <= 1'b0;
    end else begin
      if (wr) out_byte <= wdata;
      if (wr)         out_valid <= 1'b1;
      else if (!idle) out_valid <= 1'b0;
      if (wr)                      free <= 1'b0;
      else if (idle && !out_valid) free <= 1'b1;
    end
  end

  // R9
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> out_valid && out_byte == $past(wdata));
  // R8
  free_clr_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> !free);
  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !wr && !idle |=> !out_valid);
endmodule

// File: rtl/kbd_prn_port.sv
module kbd_prn_port
  import kbd_prn_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rnw,
  input  logic              bus_mrdy,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_srdy,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd_en,
  input  logic [DATA_W-1:0] key_code,
  input  logic              key_valid,
  input  logic              prn_idle,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_valid
);
  logic [DATA_W-1:0] key_byte;
  logic [DATA_W-1:0] stat_byte;
  logic key_full, key_ovr, prn_free;
  logic rd_key, rd_stat, wr_prn;

  always_comb begin
    stat_byte          = '0;
    stat_byte[ST_FULL] = key_full;
    stat_byte[ST_FREE] = prn_free;
    stat_byte[ST_OVR]  = key_ovr;
  end

  kp_bus_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) bus_u (
    .clk(clk), .rst(rst), .addr(bus_addr), .rnw(bus_rnw), .mrdy(bus_mrdy),
    .key_byte(key_byte), .stat_byte(stat_byte), .srdy(bus_srdy),
    .rd_en(bus_rd_en), .rdata(bus_rdata), .rd_key(rd_key),
    .rd_stat(rd_stat), .wr_prn(wr_prn)
  );

  kp_key_chan #(.DATA_W(DATA_W)) key_u (
    .clk(clk), .rst(rst), .code(key_code), .strobe(key_valid),
    .rd_clr(rd_key), .stat_clr(rd_stat), .held(key_byte),
    .full(key_full), .ovr(key_ovr)
  );

  kp_prn_chan #(.DATA_W(DATA_W)) prn_u (
    .clk(clk), .rst(rst), .wr(wr_prn), .wdata(bus_wdata), .idle(prn_idle),
    .out_byte(prn_data), .out_valid(prn_valid), .free(prn_free)
  );

  // R10
  stat_upper_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd_en |-> ($countones(bus_rdata[DATA_W-1:3]) == 0 ||
                   $past(bus_addr[1:0]) == 2'd0 || $past(bus_rd_en)));
endmodule

// File: tb/kbd_prn_port_tb.sv
module kbd_prn_port_tb_top;
  localparam logic [31:0] BASE   = 32'h0000_4000;
  localparam logic [31:0] A_KEY  = BASE | 32'd0;
  localparam logic [31:0] A_PRN  = BASE | 32'd1;
  localparam logic [31:0] A_STAT = BASE | 32'd2;
  localparam logic [31:0] A_NONE = BASE | 32'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic bus_rnw = 1'b1, bus_mrdy = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic bus_srdy, bus_rd_en, prn_valid;
  logic [7:0] bus_rdata, prn_data;
  logic [7:0] key_code = '0;
  logic key_valid = 1'b0, prn_idle = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_key;
  logic m_full, m_ovr, m_free;

  always #10 clk = ~clk;

  kbd_prn_port #(.BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
    .bus_mrdy(bus_mrdy), .bus_wdata(bus_wdata), .bus_srdy(bus_srdy),
    .bus_rdata(bus_rdata), .bus_rd_en(bus_rd_en), .key_code(key_code),
    .key_valid(key_valid), .prn_idle(prn_idle), .prn_data(prn_data),
    .prn_valid(prn_valid)
  );

  function automatic logic [7:0] exp_stat(logic full, logic free, logic ovr);
    return {5'b0, ovr, free, full};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_xfer(input logic [31:0] a, input logic rnw, input logic [7:0] wd,
                          output logic ok, output logic [7:0] d, output logic en);
    @(negedge clk);
    bus_addr = a; bus_rnw = rnw; bus_wdata = wd; bus_mrdy = 1'b1;
    ok = 1'b0; d = '0; en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (bus_srdy) begin
        ok = 1'b1; d = bus_rdata; en = bus_rd_en;
        break;
      end
    end
    bus_mrdy = 1'b0;
    @(negedge clk);
    chk("R3 ack released after request drop", {31'b0, bus_srdy}, 32'd0);
    chk("R4 driver enable off after release", {31'b0, bus_rd_en}, 32'd0);
  endtask

  task automatic press(input logic [7:0] c);
    @(negedge clk);
    key_code = c; key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
    @(negedge clk);
    if (m_full) m_ovr = 1'b1;
    m_full = 1'b1; m_key = c;
  endtask

  task automatic read_key_check(input string tag);
    logic ok, en; logic [7:0] d;
    bus_xfer(A_KEY, 1'b1, 8'h00, ok, d, en);
    chk({tag, " R6 ack"}, {31'b0, ok}, 32'd1);
    chk({tag, " R4 enable with data"}, {31'b0, en}, 32'd1);
    chk({tag, " R6 input byte"}, {24'b0, d}, {24'b0, m_key});
    m_full = 1'b0;
  endtask

  task automatic read_stat_check(input string tag);
    logic ok, en; logic [7:0] d;
    bus_xfer(A_STAT, 1'b1, 8'h00, ok, d, en);
    chk({tag, " R4 status ack"}, {31'b0, ok & en}, 32'd1);
    chk({tag, " R10 status byte"}, {24'b0, d}, {24'b0, exp_stat(m_full, m_free, m_ovr)});
    m_ovr = 1'b0;
  endtask

  task automatic send_check(input logic [7:0] b);
    logic ok, en; logic [7:0] d;
    bus_xfer(A_PRN, 1'b0, b, ok, d, en);
    m_free = 1'b0;
    chk("R9 write ack", {31'b0, ok}, 32'd1);
    chk("R4 no driver enable on write", {31'b0, en}, 32'd0);
    chk("R9 output strobe", {31'b0, prn_valid}, 32'd1);
    chk("R9 output byte", {24'b0, prn_data}, {24'b0, b});
    read_stat_check("R8 free cleared by write");
    prn_idle = 1'b0;
    @(negedge clk);
    chk("R9 strobe drops on busy", {31'b0, prn_valid}, 32'd0);
    prn_idle = 1'b1;
    @(negedge clk);
    @(negedge clk);
    m_free = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ok, en; logic [7:0] d;
    void'($urandom(32'd1234));
    m_key = '0; m_full = 1'b0; m_ovr = 1'b0; m_free = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 srdy", {31'b0, bus_srdy}, 32'd0);
    chk("R11 rd_en", {31'b0, bus_rd_en}, 32'd0);
    chk("R11 rdata", {24'b0, bus_rdata}, 32'd0);
    chk("R11 prn_valid", {31'b0, prn_valid}, 32'd0);
    chk("R11 prn_data", {24'b0, prn_data}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    read_stat_check("R11 status after reset");
    prn_idle = 1'b1;
    repeat (2) @(negedge clk);
    m_free = 1'b1;
    read_stat_check("R8 free when idle");

    // R1 wrong base, R2 illegal selects
    bus_xfer(32'h0000_8000, 1'b1, 8'h00, ok, d, en);
    chk("R1 other base not acknowledged", {31'b0, ok}, 32'd0);
    bus_xfer(A_NONE, 1'b1, 8'h00, ok, d, en);
    chk("R2 select 3 not acknowledged", {31'b0, ok}, 32'd0);
    bus_xfer(A_PRN, 1'b1, 8'h00, ok, d, en);
    chk("R2 read of output byte not acknowledged", {31'b0, ok}, 32'd0);
    bus_xfer(A_KEY, 1'b0, 8'h5A, ok, d, en);
    chk("R2 write to input byte not acknowledged", {31'b0, ok}, 32'd0);
    chk("R2 ignored write leaves output strobe low", {31'b0, prn_valid}, 32'd0);
    read_stat_check("R2 ignored accesses leave status");

    // R5 R6 single keystroke
    press(8'hA5);
    read_stat_check("R5 byte waiting");
    read_key_check("R5 captured code");
    read_stat_check("R6 waiting cleared");

    // R7 overrun
    press(8'h11);
    press(8'h22);
    read_stat_check("R7 overrun set");
    read_stat_check("R7 overrun cleared by status read");
    read_key_check("R7 newest code kept");

    // R3 long request hold: ack stays while request stays
    @(negedge clk);
    bus_addr = A_STAT; bus_rnw = 1'b1; bus_mrdy = 1'b1;
    repeat (5) @(negedge clk);
    chk("R3 ack held while request held", {31'b0, bus_srdy}, 32'd1);
    chk("R4 enable held while request held", {31'b0, bus_rd_en}, 32'd1);
    bus_mrdy = 1'b0;
    @(negedge clk);
    chk("R3 ack falls after request", {31'b0, bus_srdy}, 32'd0);

    // R8 R9 output path
    send_check(8'hC3);
    read_stat_check("R8 free again after device cycle");

    // random mix
    for (int n = 0; n < 300; n++) begin
      case ($urandom_range(0, 3))
        0: press(8'($urandom));
        1: if (m_full) read_key_check("R6 random read");
           else read_stat_check("R10 random status");
        2: read_stat_check("R7 random status");
        default: send_check(8'($urandom));
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule